// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Controller

This block holds the interrupt presentation state of a single processor and drives that processor's interrupt line. Its state is a 32-bit presentation word and two 8-bit priorities. The top byte of the word is the processor's current priority and the low 24 bits are the pending source number. The other two priorities are the pending priority and the priority of a software inter-processor interrupt (IPI). Priority values compare numerically: smaller is more favoured, and 0xFF means masked. A pending source number of zero means the slot is empty.

A source controller offers interrupts on a valid/ready channel. Each offer carries a source number and a priority. The block answers every offer that it takes in with a taken or refused response. The processor issues commands on a plain valid/opcode/data port. The commands set the current priority, set the IPI priority, accept the pending interrupt (the word is returned one cycle later), and signal end-of-interrupt. The block tells the source side about refused, displaced or finished sources through single-cycle reject, EOI and resend pulses. Reject and EOI share one source-number bus. The block keeps one pending slot and no queue: a source that loses its place is sent back to its origin, to be offered again after a resend.

Back-pressure rules: `offer_ready` is low in any cycle where `cmd_valid` is high, because commands take precedence. An offer is consumed only on a cycle with `offer_valid` and `offer_ready` both high. The source must hold the offer stable until then. The response arrives in the following cycle. Commands are never stalled.

Top module: `intr_present_ctrl`

## Requirements
- R1: After reset the word is 0, the pending priority is 0xFF, the IPI priority is 0xFF, `irq_out` is low and no pulse or response is issued.
- R2: An offer of priority P is refused (`offer_resp_valid` high with `offer_resp_taken` low one cycle after consumption) if P >= current priority, or if a source is pending whose pending priority <= P. A refused offer changes no state.
- R3: A taken offer answers with `offer_resp_taken` high. It loads the offered source and priority into the pending slot and raises `irq_out`. If a source was pending, that source gets a reject pulse in the same cycle as the response.
- R4: Accept (opcode 2) returns the whole word on `rsp_word` with `rsp_valid` one cycle later and lowers `irq_out`. The current priority becomes the old pending priority, the source field becomes 0 and the pending priority becomes 0xFF.
- R5: End-of-interrupt (opcode 3) copies `cmd_data[31:24]` into the current priority and issues an EOI pulse with `ntf_src` = `cmd_data[23:0]`. If no source is pending, it also performs a resend (R9) in the same cycle.
- R6: Set-current-priority (opcode 0, value in `cmd_data[7:0]`) with a value below the old one clears a pending source whose pending priority >= the new value. The clear sets the pending priority to 0xFF, lowers `irq_out` and sends a reject pulse for that source.
- R7: Set-current-priority with a value equal to or above the old one performs a resend (R9) if no source is pending, and otherwise leaves the pending slot alone.
- R8: Set-IPI-priority (opcode 1, value in `cmd_data[7:0]`) stores the value. If the value is below the current priority it runs the IPI check. The check keeps a pending source whose pending priority <= the IPI priority. Otherwise it rejects any pending source, loads source number `IPI_SRC` (2 by default) with the IPI priority, and raises `irq_out`.
- R9: A resend first runs the IPI check if the IPI priority is below the current priority, then issues a resend pulse.
- R10: `offer_ready` is low while `cmd_valid` is high. An offer presented in such a cycle is not consumed and produces no response in the following cycle.
- R11: `irq_out` is high exactly when the pending source field is non-zero.
- R12: Notification pulses appear in the cycle after the triggering event. A reject and an EOI never fall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | Offer present |
| offer_ready | output | 1 | Offer can be consumed this cycle |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| offer_resp_valid | output | 1 | Response to a consumed offer |
| offer_resp_taken | output | 1 | 1 = taken, 0 = refused |
| cmd_valid | input | 1 | Processor command present |
| cmd_op | input | 2 | 0 set current prio, 1 set IPI prio, 2 accept, 3 EOI |
| cmd_data | input | 32 | Command operand |
| rsp_valid | output | 1 | Accept result valid |
| rsp_word | output | 32 | Word returned by accept |
| ntf_reject | output | 1 | Reject pulse |
| ntf_eoi | output | 1 | EOI pulse |
| ntf_resend | output | 1 | Resend request pulse |
| ntf_src | output | 24 | Source number for reject or EOI |
| irq_out | output | 1 | Processor interrupt line |

## Verification
The two functions that can meet in one cycle are an incoming offer and a processor command. To provoke this, the bench raises an offer in the same cycle as an accept command. It then checks three things: `offer_ready` is low, the accept completes using the state from before the offer, and the held offer is taken one cycle later and judged against the current priority left behind by the accept. A scoreboard fed by a reference model compares every response, returned word and notification pulse. Many of these arise from chained actions, such as an EOI that triggers a resend, which in turn triggers an IPI load.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [1:0] {
    OP_SET_CPPR = 2'd0,
    OP_SET_IPI  = 2'd1,
    OP_ACCEPT   = 2'd2,
    OP_EOI      = 2'd3
  } ipc_op_e;
endpackage

// File: rtl/ipc_offer_judge.sv
// Decides whether an offered source may take the single pending slot.
module ipc_offer_judge #(
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 24
) (
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic [SRC_W-1:0]  held_src,
  input  logic [PRIO_W-1:0] held_prio,
  input  logic [PRIO_W-1:0] new_prio,
  output logic              take,
  output logic              displace
);
  logic occupied;
  logic too_weak;
  logic blocked;

  always_comb begin
    occupied = (held_src != '0);
    too_weak = (new_prio >= cur_prio);
    blocked  = occupied && (held_prio <= new_prio);
    take     = !too_weak && !blocked;
    displace = take && occupied;
  end
endmodule

// File: rtl/ipc_ipi_check.sv
// Software-interrupt check: may replace the pending slot with the IPI source.
module ipc_ipi_check #(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  logic              enable,
  input  logic [SRC_W-1:0]  held_src,
  input  logic [PRIO_W-1:0] held_prio,
  input  logic [PRIO_W-1:0] ipi_prio,
  output logic              load,
  output logic              evict,
  output logic [SRC_W-1:0]  next_src,
  output logic [PRIO_W-1:0] next_prio
);
  localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

  logic occupied;
  logic keep_held;

  always_comb begin
    occupied  = (held_src != '0);
    keep_held = occupied && (held_prio <= ipi_prio);
    load      = enable && !keep_held;
    evict     = load && occupied;
    next_src  = load ? IPI_NUM  : held_src;
    next_prio = load ? ipi_prio : held_prio;
  end
endmodule

// File: rtl/ipc_notify.sv
// Registers the notification requests into single-cycle pulses.
module ipc_notify #(
  parameter int SRC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_reject,
  input  logic [SRC_W-1:0] req_reject_src,
  input  logic             req_eoi,
  input  logic [SRC_W-1:0] req_eoi_src,
  input  logic             req_resend,
  output logic             ntf_reject,
  output logic             ntf_eoi,
  output logic             ntf_resend,
  output logic [SRC_W-1:0] ntf_src
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ntf_reject <= 1'b0;
      ntf_eoi    <= 1'b0;
      ntf_resend <= 1'b0;
      ntf_src    <= '0;
    end else begin
      ntf_reject <= req_reject;
      ntf_eoi    <= req_eoi;
      ntf_resend <= req_resend;
      if (req_reject) begin
        ntf_src <= req_reject_src;
      end else if (req_eoi) begin
        ntf_src <= req_eoi_src;
      end else begin
        ntf_src <= '0;
      end
    end
  end

  // R12: reject and EOI share the source bus and never coincide
  assert_shared_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(ntf_reject && ntf_eoi));

  // R12: a pulse follows its request by exactly one cycle
  assert_pulse_timing_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_resend |=> ntf_resend);
endmodule

// File: rtl/intr_present_ctrl.sv
module intr_present_ctrl #(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      offer_valid,
  output logic                      offer_ready,
  input  logic [SRC_W-1:0]          offer_src,
  input  logic [PRIO_W-1:0]         offer_prio,
  output logic                      offer_resp_valid,
  output logic                      offer_resp_taken,
  input  logic                      cmd_valid,
  input  logic [1:0]                cmd_op,
  input  logic [PRIO_W+SRC_W-1:0]   cmd_data,
  output logic                      rsp_valid,
  output logic [PRIO_W+SRC_W-1:0]   rsp_word,
  output logic                      ntf_reject,
  output logic                      ntf_eoi,
  output logic                      ntf_resend,
  output logic [SRC_W-1:0]          ntf_src,
  output logic                      irq_out
);
  import ipc_pkg::*;

  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;
  localparam logic [SRC_W-1:0]  IPI_NUM     = SRC_W'(IPI_SRC);

  // state
  logic [PRIO_W-1:0] cur_q, pend_q, ipi_q;
  logic [SRC_W-1:0]  src_q;
  logic              line_q;

  // next state
  logic [PRIO_W-1:0] cur_d, pend_d, ipi_d;
  logic [SRC_W-1:0]  src_d;
  logic              line_d;

  ipc_op_e           op;
  logic [PRIO_W-1:0] val_lo;
  logic [PRIO_W-1:0] val_hi;
  logic [SRC_W-1:0]  val_src;

  logic              take_ofr, displace_ofr;
  logic              ipi_en;
  logic [PRIO_W-1:0] ipi_prio_in;
  logic              ipi_load, ipi_evict;
  logic [SRC_W-1:0]  ipi_src_nx;
  logic [PRIO_W-1:0] ipi_prio_nx;

  logic              rej_req, eoi_req, resend_req;
  logic [SRC_W-1:0]  rej_src, eoi_src;
  logic              resp_v_d, resp_t_d, rsp_v_d;
  logic [WORD_W-1:0] rsp_w_d;

  assign op          = ipc_op_e'(cmd_op);
  assign val_lo      = cmd_data[PRIO_W-1:0];
  assign val_hi      = cmd_data[WORD_W-1 -: PRIO_W];
  assign val_src     = cmd_data[SRC_W-1:0];
  assign offer_ready = !cmd_valid;
  assign irq_out     = line_q;

  ipc_offer_judge #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_judge (
    .cur_prio  (cur_q),
    .held_src  (src_q),
    .held_prio (pend_q),
    .new_prio  (offer_prio),
    .take      (take_ofr),
    .displace  (displace_ofr)
  );

  // which command runs the IPI check, and against which priorities
  always_comb begin
    ipi_en      = 1'b0;
    ipi_prio_in = ipi_q;
    if (cmd_valid) begin
      unique case (op)
        OP_SET_IPI: begin
          ipi_prio_in = val_lo;
          ipi_en      = (val_lo < cur_q);
        end
        OP_SET_CPPR: ipi_en = (val_lo >= cur_q) && (src_q == '0) && (ipi_q < val_lo);
        OP_EOI:      ipi_en = (src_q == '0) && (ipi_q < val_hi);
        default:     ipi_en = 1'b0;
      endcase
    end
  end

  ipc_ipi_check #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_ipi (
    .enable    (ipi_en),
    .held_src  (src_q),
    .held_prio (pend_q),
    .ipi_prio  (ipi_prio_in),
    .load      (ipi_load),
    .evict     (ipi_evict),
    .next_src  (ipi_src_nx),
    .next_prio (ipi_prio_nx)
  );

  always_comb begin
    cur_d      = cur_q;
    pend_d     = pend_q;
    ipi_d      = ipi_q;
    src_d      = src_q;
    line_d     = line_q;
    rej_req    = 1'b0;
    rej_src    = '0;
    eoi_req    = 1'b0;
    eoi_src    = '0;
    resend_req = 1'b0;
    resp_v_d   = 1'b0;
    resp_t_d   = 1'b0;
    rsp_v_d    = 1'b0;
    rsp_w_d    = '0;

    if (cmd_valid) begin
      unique case (op)
        OP_SET_CPPR: begin
          cur_d = val_lo;
          if (val_lo < cur_q) begin
            if ((src_q != '0) && (val_lo <= pend_q)) begin
              src_d   = '0;
              pend_d  = PRIO_MASKED;
              line_d  = 1'b0;
              rej_req = 1'b1;
              rej_src = src_q;
            end
          end else if (src_q == '0) begin
            resend_req = 1'b1;
          end
        end
        OP_SET_IPI: begin
          ipi_d = val_lo;
        end
        OP_ACCEPT: begin
          rsp_v_d = 1'b1;
          rsp_w_d = {cur_q, src_q};
          cur_d   = pend_q;
          src_d   = '0;
          pend_d  = PRIO_MASKED;
          line_d  = 1'b0;
        end
        OP_EOI: begin
          cur_d   = val_hi;
          eoi_req = 1'b1;
          eoi_src = val_src;
          if (src_q == '0) begin
            resend_req = 1'b1;
          end
        end
        default: ;
      endcase
      if (ipi_load) begin
        src_d  = ipi_src_nx;
        pend_d = ipi_prio_nx;
        line_d = 1'b1;
      end
      if (ipi_evict) begin
        rej_req = 1'b1;
        rej_src = src_q;
      end
    end else if (offer_valid) begin
      resp_v_d = 1'b1;
      resp_t_d = take_ofr;
      if (take_ofr) begin
        src_d  = offer_src;
        pend_d = offer_prio;
        line_d = 1'b1;
      end
      if (displace_ofr) begin
        rej_req = 1'b1;
        rej_src = src_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q            <= '0;
      src_q            <= '0;
      pend_q           <= PRIO_MASKED;
      ipi_q            <= PRIO_MASKED;
      line_q           <= 1'b0;
      offer_resp_valid <= 1'b0;
      offer_resp_taken <= 1'b0;
      rsp_valid        <= 1'b0;
      rsp_word         <= '0;
    end else begin
      cur_q            <= cur_d;
      src_q            <= src_d;
      pend_q           <= pend_d;
      ipi_q            <= ipi_d;
      line_q           <= line_d;
      offer_resp_valid <= resp_v_d;
      offer_resp_taken <= resp_t_d;
      rsp_valid        <= rsp_v_d;
      rsp_word         <= rsp_w_d;
    end
  end

  ipc_notify #(.SRC_W(SRC_W)) u_notify (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_reject     (rej_req),
    .req_reject_src (rej_src),
    .req_eoi        (eoi_req),
    .req_eoi_src    (eoi_src),
    .req_resend     (resend_req),
    .ntf_reject     (ntf_reject),
    .ntf_eoi        (ntf_eoi),
    .ntf_resend     (ntf_resend),
    .ntf_src        (ntf_src)
  );

  // R11: line level follows the pending source field
  assert_line_tracks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (src_q != '0));

  // R4: accept yields a result next cycle with the line dropped
  assert_accept_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2) |=> (rsp_valid && !irq_out && src_q == '0));

  // R2: an offer no better than the current priority is refused
  assert_offer_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && offer_ready && offer_prio >= cur_q)
      |=> (offer_resp_valid && !offer_resp_taken));

  // R10: an offer seen next to a command gets no response
  assert_offer_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !offer_resp_valid);

  // R8: IPI raised on empty slot when favoured over current priority
  assert_ipi_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1 && cmd_data[PRIO_W-1:0] < cur_q && src_q == '0)
      |=> (irq_out && src_q == IPI_NUM));
endmodule

// File: tb/intr_present_ctrl_tb.sv
module intr_present_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          kind;   // 0 offer resp, 1 accept word, 2 reject, 3 eoi, 4 resend
    logic [31:0] data;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        offer_valid = 1'b0;
  logic        offer_ready;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_prio = '0;
  logic        offer_resp_valid, offer_resp_taken;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [31:0] cmd_data = '0;
  logic        rsp_valid;
  logic [31:0] rsp_word;
  logic        ntf_reject, ntf_eoi, ntf_resend;
  logic [23:0] ntf_src;
  logic        irq_out;

  int checks = 0;
  int fails = 0;
  exp_t q[$];

  // reference model state
  logic [7:0]  m_cur = 8'h00, m_pend = 8'hFF, m_ipi = 8'hFF;
  logic [23:0] m_src = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_present_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .offer_valid(offer_valid), .offer_ready(offer_ready),
    .offer_src(offer_src), .offer_prio(offer_prio),
    .offer_resp_valid(offer_resp_valid), .offer_resp_taken(offer_resp_taken),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_word(rsp_word),
    .ntf_reject(ntf_reject), .ntf_eoi(ntf_eoi), .ntf_resend(ntf_resend),
    .ntf_src(ntf_src), .irq_out(irq_out)
  );

  function automatic void check(input bit ok, input string tag,
                                input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  function automatic void push(input int kind, input logic [31:0] data, input string tag);
    exp_t e;
    e.kind = kind; e.data = data; e.tag = tag;
    q.push_back(e);
  endfunction

  function automatic void m_ipi_check(input string tag);
    if (m_src != 0 && m_pend <= m_ipi) return;
    if (m_src != 0) push(2, {8'h0, m_src}, tag);
    m_src  = 24'd2;
    m_pend = m_ipi;
  endfunction

  function automatic void m_resend(input string tag);
    if (m_ipi < m_cur) m_ipi_check(tag);
    push(4, 32'h0, tag);
  endfunction

  function automatic void m_cmd(input logic [1:0] op, input logic [31:0] d, input string tag);
    logic [7:0] old;
    case (op)
      2'd0: begin
        old = m_cur; m_cur = d[7:0];
        if (d[7:0] < old) begin
          if (m_src != 0 && d[7:0] <= m_pend) begin
            push(2, {8'h0, m_src}, tag);
            m_src = 0; m_pend = 8'hFF;
          end
        end else if (m_src == 0) m_resend(tag);
      end
      2'd1: begin
        m_ipi = d[7:0];
        if (m_ipi < m_cur) m_ipi_check(tag);
      end
      2'd2: begin
        push(1, {m_cur, m_src}, tag);
        m_cur = m_pend; m_src = 0; m_pend = 8'hFF;
      end
      default: begin
        m_cur = d[31:24];
        push(3, {8'h0, d[23:0]}, tag);
        if (m_src == 0) m_resend(tag);
      end
    endcase
  endfunction

  function automatic void m_offer(input logic [23:0] n, input logic [7:0] p, input string tag);
    if (p >= m_cur || (m_src != 0 && m_pend <= p)) begin
      push(0, 32'h0, tag);
    end else begin
      push(0, 32'h1, tag);
      if (m_src != 0) push(2, {8'h0, m_src}, tag);
      m_src = n; m_pend = p;
    end
  endfunction

  // monitor: compare each observed item with the scoreboard head
  function automatic void observe(input int kind, input logic [31:0] data);
    exp_t e;
    if (q.size() == 0) begin
      check(1'b0, "R12 unexpected", {28'h0, 4'(kind)}, 32'hFFFFFFFF);
      return;
    end
    e = q.pop_front();
    check(e.kind == kind && e.data == data, e.tag, data, e.data);
    if (e.kind != kind)
      $display("  kind mismatch: got %0d expected %0d", kind, e.kind);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (offer_resp_valid) observe(0, {31'h0, offer_resp_taken});
      if (rsp_valid)        observe(1, rsp_word);
      if (ntf_reject)       observe(2, {8'h0, ntf_src});
      if (ntf_eoi)          observe(3, {8'h0, ntf_src});
      if (ntf_resend)       observe(4, 32'h0);
    end
  end

  task automatic check_line(input string tag);
    check(irq_out == (m_src != 0), tag, {31'h0, irq_out}, {31'h0, (m_src != 0)});
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [31:0] d, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    m_cmd(op, d, tag);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check_line({tag, " line"});
  endtask

  task automatic do_offer(input logic [23:0] n, input logic [7:0] p, input string tag);
    @(negedge clk);
    offer_valid = 1'b1; offer_src = n; offer_prio = p;
    m_offer(n, p, tag);
    @(posedge clk);
    @(negedge clk);
    offer_valid = 1'b0;
    check_line({tag, " line"});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(irq_out == 1'b0, "R1 line", {31'h0, irq_out}, 32'h0);
    check(offer_ready == 1'b1, "R1 ready", {31'h0, offer_ready}, 32'h1);
    do_offer(24'd5, 8'd3, "R2 cur prio zero");
    do_cmd(2'd2, 32'h0, "R1 reset word");          // returns 0, cur becomes FF
    do_offer(24'd5, 8'd3, "R3 take");
    do_offer(24'd6, 8'd4, "R2 pending better");
    do_offer(24'd7, 8'd3, "R2 pending equal");
    do_offer(24'd8, 8'd1, "R3 displace");
    do_cmd(2'd2, 32'h0, "R4 accept");
    do_offer(24'd9, 8'd1, "R2 equal cur");
    do_offer(24'd9, 8'd0, "R3 take top");
    do_cmd(2'd2, 32'h0, "R4 accept again");
    do_cmd(2'd3, {8'hFF, 24'd9}, "R5 eoi resend");
    do_cmd(2'd1, 32'd5, "R8 ipi load");
    do_offer(24'd10, 8'd6, "R2 vs ipi");
    do_offer(24'd11, 8'd4, "R3 displace ipi");
    do_cmd(2'd0, 32'd3, "R6 clear");
    do_cmd(2'd0, 32'd8, "R9 resend ipi");
    do_cmd(2'd0, 32'd8, "R7 equal no resend");
    do_cmd(2'd1, 32'd7, "R8 ipi kept");
    do_cmd(2'd1, 32'd4, "R8 ipi evict");
    do_cmd(2'd0, 32'd6, "R6 no clear");
    // R10: offer and accept in the same cycle
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_data = 32'h0;
    offer_valid = 1'b1; offer_src = 24'd12; offer_prio = 8'd2;
    #1;
    check(offer_ready == 1'b0, "R10 stall", {31'h0, offer_ready}, 32'h0);
    m_cmd(2'd2, 32'h0, "R10 accept first");
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
    check(offer_ready == 1'b1, "R10 release", {31'h0, offer_ready}, 32'h1);
    m_offer(24'd12, 8'd2, "R10 offer after");
    @(posedge clk);
    @(negedge clk);
    offer_valid = 1'b0;
    check_line("R10 line");
    do_cmd(2'd1, 32'hFF, "R8 ipi masked");
    do_cmd(2'd3, {8'hFF, 24'd2}, "R5 eoi busy");
    do_cmd(2'd2, 32'h0, "R4 final accept");
    do_cmd(2'd3, {8'h05, 24'd12}, "R5 eoi low prio");
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R12 leftover", q.size(), 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule